// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes interrupt requests from three classes of source: a non-maskable line, a set of peripheral request lines and a set of external pin requests. Each maskable line has its own 4-bit priority level. Requests are caught in sticky pending latches. While the sequencer is idle, it picks one winner and checks that winner against the interrupt mask held in the current status register. When the winner is accepted, the decision stage takes two cycles for the non-maskable and peripheral classes and three cycles for pin requests.

After acceptance, the sequencer waits until the CPU reports that its current sequence has ended and that no mask-setting instruction is still holding off interrupts. It then runs the entry frame through a single memory port:

- status-register save,
- program-counter save,
- vector read,
- first handler fetch.

Every access lasts until the port answers ready. Five fixed overhead cycles are spread between the accesses. A done strobe marks the end of the first handler fetch. The status word the handler will run with, the final stack pointer and the handler address are all presented as outputs.

Top module: `irq_entry_seq`

## Requirements
- R1: A pending non-maskable request is accepted whatever the mask is. It beats every maskable request that is pending in the same cycle. Its level is taken as 15.
- R2: A maskable request is accepted only if its level is strictly greater than status-register bits [7:4]. Among eligible requests the highest level wins. On equal levels, peripheral lines win over pin lines, and a lower index wins within a class. A refused request stays pending.
- R3: Assume the CPU sequence has ended and every access takes one cycle. The first cycle in which a handler fetch (kind 3) is presented then comes 10 cycles after the clock edge that sampled a non-maskable or peripheral request, and 11 cycles after it for a pin request.
- R4: After the decision, the entry is held while cpu_seq_done is low or mask_defer is high. Each held cycle delays the fetch by exactly one cycle.
- R5: The accesses run in a fixed order. Kind 0 writes the sampled status register to sp_in-4. Kind 1 writes pc_in to sp_in-8. Kind 2 reads from vbr_in + 4*vector. Kind 3 reads from the address returned by that read. Only kinds 0 and 1 assert mem_we.
- R6: Each access holds mem_req, mem_kind and mem_addr stable until mem_ready. For non-maskable and peripheral requests, the response becomes 7+m1+m2+m3 cycles, where m1, m2 and m3 are the lengths of the first three accesses. For pin requests it becomes 8+m1+m2+m3 cycles.
- R7: Vector numbers are 11 for the non-maskable line, 64+i for peripheral line i and 32+i for pin i.
- R8: After an entry, sr_new equals the sampled status register with bits [7:4] replaced by the accepted level, and sp_out equals sp_in-8.
- R9: busy is low after reset. It rises in the cycle after the acceptance cycle and stays high up to and including the one-cycle done pulse, which is given in the cycle the fetch is ready. busy is low again in the next cycle.
- R10: A request that arrives while busy is high, including in the done cycle, is latched. It is served after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 1 | Non-maskable request |
| per_req | input | NPER | Peripheral request lines |
| per_lvl | input | NPER*LVL_W | Peripheral levels, line i at bits [4i+3:4i] |
| irq_req | input | NIRQ | External pin request lines |
| irq_lvl | input | NIRQ*LVL_W | Pin levels, pin i at bits [4i+3:4i] |
| sr_in | input | XLEN | Current status register, mask in bits [7:4] |
| pc_in | input | XLEN | Program counter to save |
| sp_in | input | XLEN | Stack pointer before entry |
| vbr_in | input | XLEN | Vector table base |
| cpu_seq_done | input | 1 | CPU has finished its current sequence |
| mask_defer | input | 1 | A mask-setting instruction still blocks entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_kind | output | 2 | 0 SR save, 1 PC save, 2 vector read, 3 handler fetch |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data |
| mem_ready | input | 1 | Access completes in this cycle |
| busy | output | 1 | Entry in progress |
| done | output | 1 | Handler fetch completed |
| sr_new | output | XLEN | Status word for the handler |
| sp_out | output | XLEN | Stack pointer after the two saves |
| handler_pc | output | XLEN | Handler address from the vector read |

## Verification
Two events can land in the same cycle: the done strobe of one entry and the arrival of a new request. The bench raises a pin request exactly in the cycle where done is observed high. It then requires that this request is served next, with a full three-cycle decision starting in the idle cycle after done, and that its frame is correct. A second case lands a peripheral pulse in the middle of a non-maskable entry and expects it to be served only after that entry's done strobe.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [1:0] {
      K_SRSAVE = 2'd0,
      K_PCSAVE = 2'd1,
      K_VECRD  = 2'd2,
      K_FETCH  = 2'd3
   } acc_kind_t;

   typedef enum logic [3:0] {
      S_IDLE, S_DEC, S_WAIT,
      S_OV1, S_SRW, S_OV2, S_PCW, S_OV3, S_VECR, S_OV4, S_OV5,
      S_FETCH
   } seq_state_t;

endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb #(
   parameter int NPER         = 4,
   parameter int NIRQ         = 4,
   parameter int LVL_W        = 4,
   parameter int VEC_W        = 8,
   parameter int PER_VEC_BASE = 64,
   parameter int IRQ_VEC_BASE = 32,
   localparam int NSRC        = NPER + NIRQ,
   localparam int IDX_W       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0]       pend,
   input  logic [NPER*LVL_W-1:0] per_lvl,
   input  logic [NIRQ*LVL_W-1:0] irq_lvl,
   output logic                  any,
   output logic [LVL_W-1:0]      best_lvl,
   output logic [IDX_W-1:0]      best_idx,
   output logic [VEC_W-1:0]      best_vec,
   output logic                  best_is_pin
);

   logic [LVL_W-1:0] lv [NSRC];

   for (genvar g = 0; g < NPER; g++) begin : g_per
      assign lv[g] = per_lvl[g*LVL_W +: LVL_W];
   end
   for (genvar g = 0; g < NIRQ; g++) begin : g_pin
      assign lv[NPER+g] = irq_lvl[g*LVL_W +: LVL_W];
   end

   // Scan from the highest index down; ">=" lets a lower index take a tie,
   // and peripherals sit below pins in the combined index.
   always_comb begin
      any      = 1'b0;
      best_lvl = '0;
      best_idx = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend[i] && (!any || lv[i] >= best_lvl)) begin
            any      = 1'b1;
            best_lvl = lv[i];
            best_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      best_is_pin = (int'(best_idx) >= NPER);
      if (best_is_pin) best_vec = VEC_W'(IRQ_VEC_BASE + int'(best_idx) - NPER);
      else             best_vec = VEC_W'(PER_VEC_BASE + int'(best_idx));
   end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
   import irq_entry_pkg::*;
#(
   parameter int DEC_FAST = 2,
   parameter int DEC_SLOW = 3,
   localparam int CNT_W   = $clog2(DEC_SLOW + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       start_slow,
   input  logic       seq_ok,
   input  logic       mem_ready,
   output logic       idle,
   output logic       busy,
   output logic       load_ctx,
   output logic       vec_cap,
   output logic       done,
   output logic       mem_req,
   output logic [1:0] mem_kind
);

   seq_state_t       state;
   logic [CNT_W-1:0] dec_cnt;
   acc_kind_t        kind;

   assign load_ctx = ((state == S_DEC) && (dec_cnt == '0) && seq_ok) ||
                     ((state == S_WAIT) && seq_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         dec_cnt <= '0;
      end else begin
         case (state)
            S_IDLE:  if (start) begin
                        state   <= S_DEC;
                        dec_cnt <= start_slow ? CNT_W'(DEC_SLOW - 2) : CNT_W'(DEC_FAST - 2);
                     end
            S_DEC:   if (dec_cnt != '0) dec_cnt <= dec_cnt - 1'b1;
                     else if (seq_ok)   state <= S_OV1;
                     else               state <= S_WAIT;
            S_WAIT:  if (seq_ok) state <= S_OV1;
            S_OV1:   state <= S_SRW;
            S_SRW:   if (mem_ready) state <= S_OV2;
            S_OV2:   state <= S_PCW;
            S_PCW:   if (mem_ready) state <= S_OV3;
            S_OV3:   state <= S_VECR;
            S_VECR:  if (mem_ready) state <= S_OV4;
            S_OV4:   state <= S_OV5;
            S_OV5:   state <= S_FETCH;
            S_FETCH: if (mem_ready) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req = 1'b1;
      kind    = K_SRSAVE;
      case (state)
         S_SRW:   kind = K_SRSAVE;
         S_PCW:   kind = K_PCSAVE;
         S_VECR:  kind = K_VECRD;
         S_FETCH: kind = K_FETCH;
         default: mem_req = 1'b0;
      endcase
   end

   assign mem_kind = kind;
   assign idle     = (state == S_IDLE);
   assign busy     = !idle;
   assign vec_cap  = (state == S_VECR) && mem_ready;
   assign done     = (state == S_FETCH) && mem_ready;

   assert_kind_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_kind)));

   assert_entry_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_OV1) |-> $past(seq_ok));

   assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int NPER         = 4,
   parameter int NIRQ         = 4,
   parameter int LVL_W        = 4,
   parameter int VEC_W        = 8,
   parameter int XLEN         = 32,
   parameter int MASK_LSB     = 4,
   parameter int NMI_VEC      = 11,
   parameter int PER_VEC_BASE = 64,
   parameter int IRQ_VEC_BASE = 32,
   parameter int DEC_FAST     = 2,
   parameter int DEC_SLOW     = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  nmi_req,
   input  logic [NPER-1:0]       per_req,
   input  logic [NPER*LVL_W-1:0] per_lvl,
   input  logic [NIRQ-1:0]       irq_req,
   input  logic [NIRQ*LVL_W-1:0] irq_lvl,
   input  logic [XLEN-1:0]       sr_in,
   input  logic [XLEN-1:0]       pc_in,
   input  logic [XLEN-1:0]       sp_in,
   input  logic [XLEN-1:0]       vbr_in,
   input  logic                  cpu_seq_done,
   input  logic                  mask_defer,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [1:0]            mem_kind,
   output logic [XLEN-1:0]       mem_addr,
   output logic [XLEN-1:0]       mem_wdata,
   input  logic [XLEN-1:0]       mem_rdata,
   input  logic                  mem_ready,
   output logic                  busy,
   output logic                  done,
   output logic [XLEN-1:0]       sr_new,
   output logic [XLEN-1:0]       sp_out,
   output logic [XLEN-1:0]       handler_pc
);

   localparam int NSRC  = NPER + NIRQ;
   localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (DEC_FAST < 2 || DEC_SLOW < DEC_FAST) begin : g_bad_dec
      $error("decision latencies must satisfy 2 <= DEC_FAST <= DEC_SLOW");
   end
   if (MASK_LSB + LVL_W > XLEN || VEC_W + 2 > XLEN) begin : g_bad_width
      $error("mask field or scaled vector does not fit in XLEN");
   end
   if (NPER < 1 || NIRQ < 1) begin : g_bad_count
      $error("each maskable class needs at least one line");
   end

   // pending latches
   logic            nmi_pend;
   logic [NSRC-1:0] src_pend, src_clr;
   logic            arb_any, arb_pin;
   logic [LVL_W-1:0] arb_lvl, cur_mask;
   logic [IDX_W-1:0] arb_idx;
   logic [VEC_W-1:0] arb_vec;
   logic            idle, accept, load_ctx, vec_cap;

   irq_entry_arb #(
      .NPER(NPER), .NIRQ(NIRQ), .LVL_W(LVL_W), .VEC_W(VEC_W),
      .PER_VEC_BASE(PER_VEC_BASE), .IRQ_VEC_BASE(IRQ_VEC_BASE)
   ) u_arb (
      .pend(src_pend), .per_lvl(per_lvl), .irq_lvl(irq_lvl),
      .any(arb_any), .best_lvl(arb_lvl), .best_idx(arb_idx),
      .best_vec(arb_vec), .best_is_pin(arb_pin)
   );

   assign cur_mask = sr_in[MASK_LSB +: LVL_W];
   assign accept   = idle && (nmi_pend || (arb_any && (arb_lvl > cur_mask)));
   assign src_clr  = (accept && !nmi_pend) ? (NSRC'(1) << arb_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_pend <= 1'b0;
         src_pend <= '0;
      end else begin
         nmi_pend <= (nmi_pend | nmi_req) & ~(accept & nmi_pend);
         src_pend <= (src_pend | {irq_req, per_req}) & ~src_clr;
      end
   end

   // accepted winner
   logic             cur_nmi;
   logic [LVL_W-1:0] cur_lvl;
   logic [VEC_W-1:0] cur_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_nmi <= 1'b0;
         cur_lvl <= '0;
         cur_vec <= '0;
      end else if (accept) begin
         cur_nmi <= nmi_pend;
         cur_lvl <= nmi_pend ? '1 : arb_lvl;
         cur_vec <= nmi_pend ? VEC_W'(NMI_VEC) : arb_vec;
      end
   end

   irq_entry_fsm #(.DEC_FAST(DEC_FAST), .DEC_SLOW(DEC_SLOW)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .start(accept), .start_slow(!nmi_pend && arb_pin),
      .seq_ok(cpu_seq_done && !mask_defer), .mem_ready(mem_ready),
      .idle(idle), .busy(busy), .load_ctx(load_ctx), .vec_cap(vec_cap),
      .done(done), .mem_req(mem_req), .mem_kind(mem_kind)
   );

   // context captured when the entry frame begins
   logic [XLEN-1:0] sr_q, pc_q, sp_q, vbr_q, srn_q, hnd_q, srn_d;

   always_comb begin
      srn_d = sr_in;
      srn_d[MASK_LSB +: LVL_W] = cur_lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0; pc_q <= '0; sp_q <= '0; vbr_q <= '0; srn_q <= '0; hnd_q <= '0;
      end else begin
         if (load_ctx) begin
            sr_q  <= sr_in;
            pc_q  <= pc_in;
            sp_q  <= sp_in;
            vbr_q <= vbr_in;
            srn_q <= srn_d;
         end
         if (vec_cap) hnd_q <= mem_rdata;
      end
   end

   always_comb begin
      mem_addr  = hnd_q;
      mem_wdata = '0;
      mem_we    = 1'b0;
      case (acc_kind_t'(mem_kind))
         K_SRSAVE: begin mem_addr = sp_q - XLEN'(4); mem_wdata = sr_q; mem_we = mem_req; end
         K_PCSAVE: begin mem_addr = sp_q - XLEN'(8); mem_wdata = pc_q; mem_we = mem_req; end
         K_VECRD:  mem_addr = vbr_q + (XLEN'(cur_vec) << 2);
         default:  mem_addr = hnd_q;
      endcase
   end

   assign sr_new     = srn_q;
   assign sp_out     = sp_q - XLEN'(8);
   assign handler_pc = hnd_q;

   assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   assert_mask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (cur_nmi || (cur_lvl > $past(cur_mask))));

   assert_nmi_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(nmi_pend)) |-> cur_nmi);

endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] SR_BASE = 32'h4000_0003;
   localparam logic [31:0] PC_VAL  = 32'h0123_4568;
   localparam logic [31:0] SP_VAL  = 32'h0000_8000;
   localparam logic [31:0] VBR_VAL = 32'h1000_0000;
   localparam logic [31:0] RD_XOR  = 32'h5A00_0000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        nmi_req = 1'b0;
   logic [3:0]  per_req = '0, irq_req = '0;
   logic [15:0] per_lvl = '0, irq_lvl = '0;
   logic [31:0] sr_in = SR_BASE, pc_in = PC_VAL, sp_in = SP_VAL, vbr_in = VBR_VAL;
   logic        cpu_seq_done = 1'b1, mask_defer = 1'b0;
   logic        mem_req, mem_we, mem_ready, busy, done;
   logic [1:0]  mem_kind;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, sr_new, sp_out, handler_pc;

   int tests = 0, fails = 0, cyc = 0, acc_cnt = 0;
   int lat [4];
   logic [31:0] log_addr [4];
   logic [31:0] log_data [4];
   logic        log_we   [4];
   int          log_t    [4];

   irq_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .per_req(per_req), .per_lvl(per_lvl),
      .irq_req(irq_req), .irq_lvl(irq_lvl), .sr_in(sr_in), .pc_in(pc_in), .sp_in(sp_in),
      .vbr_in(vbr_in), .cpu_seq_done(cpu_seq_done), .mask_defer(mask_defer),
      .mem_req(mem_req), .mem_we(mem_we), .mem_kind(mem_kind), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .busy(busy), .done(done), .sr_new(sr_new), .sp_out(sp_out), .handler_pc(handler_pc)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // memory model with per-kind access length
   assign mem_ready = mem_req && ((acc_cnt + 1) >= lat[mem_kind]);
   assign mem_rdata = mem_addr ^ RD_XOR;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!mem_req || mem_ready) acc_cnt <= 0;
      else                       acc_cnt <= acc_cnt + 1;
      if (mem_req && mem_ready) begin
         log_addr[mem_kind] <= mem_addr;
         log_data[mem_kind] <= mem_wdata;
         log_we[mem_kind]   <= mem_we;
         log_t[mem_kind]    <= cyc;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_lat(input int a, input int b, input int c, input int d);
      lat[0] = a; lat[1] = b; lat[2] = c; lat[3] = d;
   endtask

   task automatic pulse(input logic n, input logic [3:0] p, input logic [3:0] q);
      @(negedge clk);
      nmi_req = n; per_req = p; irq_req = q;
      @(negedge clk);
      nmi_req = 1'b0; per_req = '0; irq_req = '0;
   endtask

   // Cycle 1 is the current cycle on entry. Returns the response (fetch cycle - 1).
   task automatic measure(input int rel_n, input int per_n, input logic [3:0] per_v,
                          input logic [3:0] irq_at_done, output int resp, output int fdone,
                          output logic b1, output logic b2, output logic pb);
      int  n;
      bit  seen;
      n = 1; resp = -1; fdone = -1; seen = 0; b1 = busy; b2 = 1'b0;
      while (n < 400) begin
         if (n == rel_n) begin cpu_seq_done = 1'b1; mask_defer = 1'b0; end
         if (n == per_n) per_req = per_v;
         if (n == per_n + 1) per_req = '0;
         if (n == 2) b2 = busy;
         if (!seen && mem_req && mem_kind == 2'd3) begin seen = 1; resp = n - 1; end
         if (done) begin fdone = n; break; end
         @(negedge clk);
         n++;
      end
      irq_req = irq_at_done;
      @(negedge clk);
      irq_req = '0;
      pb = busy;
      if (fdone < 0) check("R9 done never seen", 32'd0, 32'd1);
   endtask

   task automatic check_frame(input string tag, input int vec, input logic [3:0] lvl);
      logic [31:0] va;
      va = VBR_VAL + 32'(vec * 4);
      check({tag, " R5 SR save addr"}, log_addr[0], SP_VAL - 4);
      check({tag, " R5 SR save data"}, log_data[0], sr_in);
      check({tag, " R5 PC save addr"}, log_addr[1], SP_VAL - 8);
      check({tag, " R5 PC save data"}, log_data[1], PC_VAL);
      check({tag, " R5 write enables"}, {30'd0, log_we[1], log_we[0]}, 32'd3);
      check({tag, " R5 vector read not write"}, {31'd0, log_we[2]}, 32'd0);
      check({tag, " R7 vector addr"}, log_addr[2], va);
      check({tag, " R5 fetch addr"}, log_addr[3], va ^ RD_XOR);
      check({tag, " R5 order"}, {29'd0, log_t[0] < log_t[1], log_t[1] < log_t[2], log_t[2] < log_t[3]}, 32'd7);
      check({tag, " R8 sr_new"}, sr_new, (sr_in & ~32'h0000_00F0) | {24'd0, lvl, 4'd0});
      check({tag, " R8 sp_out"}, sp_out, SP_VAL - 8);
      check({tag, " R5 handler_pc"}, handler_pc, va ^ RD_XOR);
   endtask

   task automatic t_reset;
      check("R9 reset busy", {31'd0, busy}, 32'd0);
      check("R9 reset done", {31'd0, done}, 32'd0);
      check("R9 reset mem_req", {31'd0, mem_req}, 32'd0);
   endtask

   task automatic t_nmi_min;
      int r, f; logic b1, b2, pb;
      set_lat(1, 1, 1, 1);
      sr_in = SR_BASE | 32'h0000_00F0;
      pulse(1'b1, '0, '0);
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R3 NMI response", r, 10);
      check("R1 NMI accepted under mask 15", {31'd0, f > 0}, 32'd1);
      check("R9 busy low in accept cycle", {31'd0, b1}, 32'd0);
      check("R9 busy high after accept", {31'd0, b2}, 32'd1);
      check("R9 busy low after done", {31'd0, pb}, 32'd0);
      check_frame("nmi", 11, 4'hF);
   endtask

   task automatic t_pin_min;
      int r, f; logic b1, b2, pb;
      set_lat(1, 1, 1, 1);
      sr_in = SR_BASE | 32'h0000_0030;
      irq_lvl = 16'h0500;
      pulse(1'b0, '0, 4'b0100);
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R3 pin response", r, 11);
      check_frame("pin2", 34, 4'h5);
   endtask

   task automatic t_stretch;
      int r, f; logic b1, b2, pb;
      sr_in = SR_BASE;
      per_lvl = 16'h0040;
      set_lat(2, 3, 1, 2);
      pulse(1'b0, 4'b0010, '0);
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R6 peripheral stretched response", r, 13);
      check("R6 done after two-cycle fetch", f - r, 2);
      check_frame("per1", 65, 4'h4);
      irq_lvl = 16'h0009;
      set_lat(1, 1, 4, 1);
      pulse(1'b0, '0, 4'b0001);
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R6 pin stretched response", r, 14);
      check_frame("pin0", 32, 4'h9);
   endtask

   task automatic t_defer;
      int r, f; logic b1, b2, pb;
      set_lat(1, 1, 1, 1);
      sr_in = SR_BASE;
      cpu_seq_done = 1'b0;
      pulse(1'b1, '0, '0);
      measure(4, -9, '0, '0, r, f, b1, b2, pb);
      check("R4 sequence wait adds 2", r, 12);
      mask_defer = 1'b1;
      pulse(1'b1, '0, '0);
      measure(6, -9, '0, '0, r, f, b1, b2, pb);
      check("R4 masking deferral adds 4", r, 14);
      check_frame("defer", 11, 4'hF);
   endtask

   task automatic t_mask;
      int r, f; logic b1, b2, pb; bit moved;
      set_lat(1, 1, 1, 1);
      sr_in = SR_BASE | 32'h0000_0030;
      irq_lvl = 16'h0030;
      pulse(1'b0, '0, 4'b0010);
      moved = 0;
      for (int i = 0; i < 20; i++) begin
         if (busy || mem_req) moved = 1;
         @(negedge clk);
      end
      check("R2 equal level refused", {31'd0, moved}, 32'd0);
      sr_in = SR_BASE | 32'h0000_0020;
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R2 pending kept and served after mask drop", r, 11);
      check_frame("mask", 33, 4'h3);
   endtask

   task automatic t_prio_nmi;
      int r, f; logic b1, b2, pb; bit moved;
      set_lat(1, 1, 1, 1);
      sr_in = SR_BASE | 32'h0000_00F0;
      irq_lvl = 16'hF000;
      pulse(1'b1, '0, 4'b1000);
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R1 NMI beats level-15 pin", log_addr[2], VBR_VAL + 32'd44);
      moved = 0;
      for (int i = 0; i < 10; i++) begin
         if (busy || mem_req) moved = 1;
         @(negedge clk);
      end
      check("R2 level 15 refused under mask 15", {31'd0, moved}, 32'd0);
      sr_in = SR_BASE;
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R2 pin served after unmask", r, 11);
      check_frame("pin3", 35, 4'hF);
   endtask

   task automatic t_prio_lvl;
      int r, f; logic b1, b2, pb;
      set_lat(1, 1, 1, 1);
      sr_in = SR_BASE;
      per_lvl = 16'h0650;
      irq_lvl = 16'h0006;
      pulse(1'b0, 4'b0110, 4'b0001);
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R2 tie goes to peripheral", r, 10);
      check_frame("tie", 66, 4'h6);
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R2 higher level pin next", r, 11);
      check_frame("lvl", 32, 4'h6);
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R2 lowest level last", r, 10);
      check_frame("last", 65, 4'h5);
   endtask

   task automatic t_busy_latch;
      int r, f; logic b1, b2, pb;
      set_lat(1, 1, 1, 1);
      sr_in = SR_BASE;
      per_lvl = 16'h2000;
      pulse(1'b1, '0, '0);
      measure(0, 5, 4'b1000, '0, r, f, b1, b2, pb);
      check("R10 NMI frame first", log_addr[2], VBR_VAL + 32'd44);
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R10 request latched while busy served next", r, 10);
      check_frame("latched", 67, 4'h2);
   endtask

   task automatic t_same_cycle;
      int r, f; logic b1, b2, pb;
      set_lat(1, 1, 1, 1);
      sr_in = SR_BASE;
      irq_lvl = 16'h0070;
      pulse(1'b1, '0, '0);
      measure(0, -9, '0, 4'b0010, r, f, b1, b2, pb);
      check("R10 first entry completes", r, 10);
      measure(0, -9, '0, '0, r, f, b1, b2, pb);
      check("R10 request in done cycle served", r, 11);
      check_frame("samecyc", 33, 4'h7);
   endtask

   initial begin
      set_lat(1, 1, 1, 1);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_nmi_min();
      t_pin_min();
      t_stretch();
      t_defer();
      t_mask();
      t_prio_nmi();
      t_prio_lvl();
      t_busy_latch();
      t_same_cycle();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule